// File: doc/BRIEF.md
# Quasi-Bidirectional Port Controller

This block is the digital core of an eight-bit general-purpose port in which every pin is an output and an input at once. There is no direction register. A bit holding zero pulls its pin low. A bit holding one releases the pin, which then rests high through pull-ups, so an outside device can pull it low and be read. The block stores the port latch. It accepts whole-byte writes and single-bit writes from the processor. It brings the pad levels in through a synchronizer. It generates the four per-bit enables for the pad: one pull-down and three pull-ups of different strength.

A read has two forms. An ordinary read returns the synchronized pin levels. A read flagged by `rmw_read` returns the latch contents. This protects read-modify-write sequences from a pin whose external load keeps it below the logic-one threshold. The pad enables are registered one cycle behind the latch. On each zero-to-one change of a driven bit, the strong pull-up is pulsed for a fixed number of cycles to speed the rising edge.

Top module: `qbp_port`

## Requirements
- R1: Reset leaves every latch bit at one. It also leaves `pd_en` at all zeros, `pu_strong` at all zeros, `pu_vweak` at all ones and the synchronized pin value at all ones.
- R2: While `rmw_read` is 1, `rd_data` equals the latch contents in the same cycle, whatever the pin levels are.
- R3: While `rmw_read` is 0, `rd_data` equals `pin_in` as sampled two rising clock edges earlier, through a two-stage synchronizer.
- R4: When `wr_byte` is high at a rising edge, the latch takes `wr_byte_data` at that edge.
- R5: When `wr_bit` is high and `wr_byte` is low at a rising edge, latch bit `wr_bit_idx` (bit 0 is the LSB) takes `wr_bit_val`. All other latch bits keep their values.
- R6: When `wr_byte` and `wr_bit` are high at the same edge, only the byte write takes effect.
- R7: `pd_en` bit i equals the inverse of latch bit i as it was one clock earlier, so a pad drive change lags the latch change by one cycle.
- R8: When a bit of the registered drive goes from 0 to 1, `pu_strong` for that bit is 1 for exactly two cycles, starting in the cycle the drive becomes 1, and is then 0.
- R9: If a latch bit returns to 0 while its strong pulse is running, the pulse ends at the next edge. A fresh 0-to-1 change always restarts a full pulse.
- R10: `pu_weak` bit i equals the synchronized pin level of bit i.
- R11: `pu_vweak` bit i is 1 exactly when `pd_en` bit i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_byte | input | 1 | Whole-byte latch write strobe |
| wr_byte_data | input | 8 | Byte to load into the latch |
| wr_bit | input | 1 | Single-bit latch write strobe |
| wr_bit_idx | input | 3 | Index of the bit to modify |
| wr_bit_val | input | 1 | New value for the indexed bit |
| rmw_read | input | 1 | Read selects the latch instead of the pins |
| rd_data | output | 8 | Read result |
| pin_in | input | 8 | Raw pad input levels |
| pd_en | output | 8 | Per-bit pull-down enable |
| pu_strong | output | 8 | Per-bit timed strong pull-up enable |
| pu_weak | output | 8 | Per-bit keeper pull-up enable |
| pu_vweak | output | 8 | Per-bit very weak pull-up enable |

## Verification
The embedded properties assume that `wr_bit_idx` is a legal bit number whenever `wr_bit` is high. They also assume that the reset is held long enough for the latch, drive and synchronizer registers to settle. The stimulus uses only indices 0 to 7. It changes every input on the falling clock edge, so each write strobe and pin change is seen by exactly one rising edge. Pulse tests leave idle cycles between write patterns, so one bit's pulse has expired before the next case on that bit starts.

// File: rtl/qbp_pkg.sv
package qbp_pkg;
   // Number of oscillator cycles the strong pull-up burst lasts
   localparam int unsigned QBP_BOOST_DEFAULT = 2;
   // Number of synchronizer flops on the pin path
   localparam int unsigned QBP_SYNC_DEFAULT  = 2;

   // Write command after priority resolution
   typedef enum logic [1:0] {
      WR_NONE = 2'd0,
      WR_BYTE = 2'd1,
      WR_BIT  = 2'd2
   } wr_kind_e;
endpackage

// File: rtl/qbp_sync.sv
module qbp_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("qbp_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= '1;
               else        stg[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '1;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign d_out = stg[STAGES-1];
endmodule

// File: rtl/qbp_latch.sv
module qbp_latch
   import qbp_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_byte,
   input  logic [WIDTH-1:0] wr_byte_data,
   input  logic             wr_bit,
   input  logic [IDX_W-1:0] wr_bit_idx,
   input  logic             wr_bit_val,
   output logic [WIDTH-1:0] latch_q
);
   wr_kind_e         kind;
   logic [WIDTH-1:0] bit_mask;
   logic [WIDTH-1:0] latch_d;

   always_comb begin
      if (wr_byte)     kind = WR_BYTE;
      else if (wr_bit) kind = WR_BIT;
      else             kind = WR_NONE;
   end

   always_comb begin
      bit_mask = '0;
      bit_mask[wr_bit_idx] = 1'b1;
   end

   always_comb begin
      unique case (kind)
         WR_BYTE: latch_d = wr_byte_data;
         WR_BIT:  latch_d = wr_bit_val ? (latch_q | bit_mask)
                                       : (latch_q & ~bit_mask);
         default: latch_d = latch_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latch_q <= '1;
      else        latch_q <= latch_d;
   end

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_byte && !wr_bit) |=> $stable(latch_q));                          // R4
   AST_BYTE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_byte |=> (latch_q == $past(wr_byte_data)));                        // R6
   AST_BIT_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_bit && !wr_byte) |=>
         ((latch_q ^ $past(latch_q)) & ~(WIDTH'(1) << $past(wr_bit_idx))) == '0); // R5
endmodule

// File: rtl/qbp_boost.sv
module qbp_boost #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned CYCLES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] latch_q,
   input  logic [WIDTH-1:0] drv_q,
   output logic [WIDTH-1:0] strong_en
);
   localparam int unsigned CNT_W = $clog2(CYCLES + 1);

   generate
      if (CYCLES < 1) begin : g_bad
         $error("qbp_boost: CYCLES must be at least 1");
      end
   endgenerate

   // The drive register takes latch_q at the same edge, so a rise of the
   // drive is seen here as latch one over drive zero.
   logic [WIDTH-1:0] rise;
   assign rise = latch_q & ~drv_q;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         if (CYCLES == 1) begin : g_flop
            logic on_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) on_q <= 1'b0;
               else        on_q <= rise[i];
            end
            assign strong_en[i] = on_q;
         end else begin : g_count
            logic [CNT_W-1:0] cnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)              cnt_q <= '0;
               else if (rise[i])        cnt_q <= CNT_W'(CYCLES);
               else if (!latch_q[i])    cnt_q <= '0;
               else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
            end
            assign strong_en[i] = (cnt_q != '0);
         end

         AST_BOOST_START: assert property (@(posedge clk) disable iff (!rst_n)
            (drv_q[i] && !$past(drv_q[i])) |-> strong_en[i]);                // R8
         AST_BOOST_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
            strong_en[i] |-> drv_q[i]);                                      // R9
      end
   endgenerate
endmodule

// File: rtl/qbp_port.sv
module qbp_port
   import qbp_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = QBP_SYNC_DEFAULT,
   parameter int unsigned BOOST_CYC   = QBP_BOOST_DEFAULT,
   localparam int unsigned IDX_W      = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_byte,
   input  logic [WIDTH-1:0] wr_byte_data,
   input  logic             wr_bit,
   input  logic [IDX_W-1:0] wr_bit_idx,
   input  logic             wr_bit_val,
   input  logic             rmw_read,
   output logic [WIDTH-1:0] rd_data,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pd_en,
   output logic [WIDTH-1:0] pu_strong,
   output logic [WIDTH-1:0] pu_weak,
   output logic [WIDTH-1:0] pu_vweak
);
   generate
      if (WIDTH < 1) begin : g_bad
         $error("qbp_port: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] drv_q;
   logic [WIDTH-1:0] pin_s;

   qbp_latch #(.WIDTH(WIDTH)) u_latch (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_byte      (wr_byte),
      .wr_byte_data (wr_byte_data),
      .wr_bit       (wr_bit),
      .wr_bit_idx   (wr_bit_idx),
      .wr_bit_val   (wr_bit_val),
      .latch_q      (latch_q)
   );

   qbp_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pin_in),
      .d_out (pin_s)
   );

   // Pad drive stage: one cycle behind the latch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drv_q <= '1;
      else        drv_q <= latch_q;
   end

   qbp_boost #(.WIDTH(WIDTH), .CYCLES(BOOST_CYC)) u_boost (
      .clk       (clk),
      .rst_n     (rst_n),
      .latch_q   (latch_q),
      .drv_q     (drv_q),
      .strong_en (pu_strong)
   );

   assign pd_en    = ~drv_q;
   assign pu_vweak = drv_q;
   assign pu_weak  = pin_s;
   assign rd_data  = rmw_read ? latch_q : pin_s;

   AST_DRIVE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (pd_en == ~$past(latch_q)));                                 // R7
   AST_VWEAK_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(latch_q[0]) |=> !pu_vweak[0]);                                   // R11
endmodule

// File: tb/tb_qbp_port.sv
module tb_qbp_port;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_byte = 1'b0;
   logic [W-1:0] wr_byte_data = '0;
   logic         wr_bit = 1'b0;
   logic [2:0]   wr_bit_idx = '0;
   logic         wr_bit_val = 1'b0;
   logic         rmw_read = 1'b0;
   logic [W-1:0] rd_data;
   logic [W-1:0] pin_in = '1;
   logic [W-1:0] pd_en, pu_strong, pu_weak, pu_vweak;

   always #10 clk = ~clk;   // 50 MHz

   qbp_port dut (
      .clk(clk), .rst_n(rst_n),
      .wr_byte(wr_byte), .wr_byte_data(wr_byte_data),
      .wr_bit(wr_bit), .wr_bit_idx(wr_bit_idx), .wr_bit_val(wr_bit_val),
      .rmw_read(rmw_read), .rd_data(rd_data), .pin_in(pin_in),
      .pd_en(pd_en), .pu_strong(pu_strong), .pu_weak(pu_weak), .pu_vweak(pu_vweak)
   );

   typedef enum int { S_RD, S_PD, S_ST, S_WK, S_VW } sel_e;
   typedef struct {
      sel_e         sel;
      logic [W-1:0] exp;
      string        tag;
   } item_t;

   item_t sb[$];
   int    checks = 0;
   int    failures = 0;
   bit    done = 1'b0;

   function automatic logic [W-1:0] observe(sel_e s);
      case (s)
         S_RD:    return rd_data;
         S_PD:    return pd_en;
         S_ST:    return pu_strong;
         S_WK:    return pu_weak;
         default: return pu_vweak;
      endcase
   endfunction

   task automatic expect_now(sel_e s, logic [W-1:0] v, string tag);
      item_t it;
      it.sel = s; it.exp = v; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // Monitor: compares queued expectations 1 ns after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sb.size() > 0) begin
            item_t it;
            logic [W-1:0] act;
            it  = sb.pop_front();
            act = observe(it.sel);
            checks++;
            if (act !== it.exp) begin
               failures++;
               $display("FAIL %s sel=%s actual=%02h expected=%02h",
                        it.tag, it.sel.name(), act, it.exp);
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      rmw_read = 1'b1;
      // R1: reset state
      expect_now(S_RD, 8'hFF, "R1");
      expect_now(S_PD, 8'h00, "R1");
      expect_now(S_ST, 8'h00, "R1");
      expect_now(S_VW, 8'hFF, "R1");
      tick();

      // R4 / R7 / R11: byte write, drive lags one cycle
      wr_byte = 1'b1; wr_byte_data = 8'h5A;
      tick();
      wr_byte = 1'b0;
      expect_now(S_RD, 8'h5A, "R4");
      expect_now(S_PD, 8'h00, "R7");
      tick();
      expect_now(S_PD, 8'hA5, "R7");
      expect_now(S_VW, 8'h5A, "R11");
      expect_now(S_ST, 8'h00, "R8");

      // R3 / R10: pin path through two flops
      pin_in = 8'h5A; rmw_read = 1'b0;
      expect_now(S_RD, 8'hFF, "R3");
      tick();
      expect_now(S_RD, 8'hFF, "R3");
      tick();
      expect_now(S_RD, 8'h5A, "R3");
      expect_now(S_WK, 8'h5A, "R10");

      // R5 / R8: bit 0 set, strong pulse two cycles
      rmw_read = 1'b1;
      wr_bit = 1'b1; wr_bit_idx = 3'd0; wr_bit_val = 1'b1;
      tick();
      wr_bit = 1'b0;
      expect_now(S_RD, 8'h5B, "R5");
      expect_now(S_ST, 8'h00, "R8");
      tick();
      expect_now(S_ST, 8'h01, "R8");
      expect_now(S_PD, 8'hA4, "R7");
      tick();
      expect_now(S_ST, 8'h01, "R8");
      tick();
      expect_now(S_ST, 8'h00, "R8");

      // R6: byte write beats simultaneous bit write
      wr_byte = 1'b1; wr_byte_data = 8'h0F;
      wr_bit = 1'b1; wr_bit_idx = 3'd7; wr_bit_val = 1'b1;
      tick();
      wr_byte = 1'b0; wr_bit = 1'b0;
      expect_now(S_RD, 8'h0F, "R6");

      // R5: clear bit 2 only
      wr_bit = 1'b1; wr_bit_idx = 3'd2; wr_bit_val = 1'b0;
      tick();
      wr_bit = 1'b0;
      expect_now(S_RD, 8'h0B, "R5");
      repeat (4) tick();
      expect_now(S_ST, 8'h00, "R8");

      // R9: bit 4 set then cleared, pulse cut short
      wr_bit = 1'b1; wr_bit_idx = 3'd4; wr_bit_val = 1'b1;
      tick();
      wr_bit_val = 1'b0;
      tick();
      wr_bit = 1'b0;
      expect_now(S_ST, 8'h10, "R8");
      tick();
      expect_now(S_ST, 8'h00, "R9");
      expect_now(S_PD, 8'hF4, "R7");

      // R9: a fresh rise on bit 4 gives a full pulse again
      wr_bit = 1'b1; wr_bit_idx = 3'd4; wr_bit_val = 1'b1;
      tick();
      wr_bit = 1'b0;
      tick();
      expect_now(S_ST, 8'h10, "R9");
      tick();
      expect_now(S_ST, 8'h10, "R9");
      tick();
      expect_now(S_ST, 8'h00, "R9");

      // R2 / R3: latch and pins disagree
      pin_in = 8'h33; rmw_read = 1'b0;
      tick();
      tick();
      expect_now(S_RD, 8'h33, "R3");
      expect_now(S_WK, 8'h33, "R10");
      tick();
      rmw_read = 1'b1;
      expect_now(S_RD, 8'h1B, "R2");
      tick();
      tick();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule